// File: doc/BRIEF.md
# Error Status Query Responder

This block answers error-status queries that arrive one byte at a time over an auxiliary link. It keeps three sticky error flags: sequence error, collision and busy. Each flag has a channel register that is loaded with the channel number on the event that sets the flag. Later events of the same kind leave that register alone while the flag is still pending. Event pulses and their channel numbers come in on dedicated inputs, one lane per error kind.

When a query byte arrives, the block picks one pending error by fixed priority. It clears that error's flag and streams back a reply frame on an 8-bit valid/ready output. The frame is either a one-byte "no error" code, or an error code followed by the captured channel number. A host drains all pending errors by sending repeated queries until the no-error code comes back. Errors that are not reported stay pending for later queries.

Top module: `err_status_resp`

## Requirements
- R1: After the active-low asynchronous reset, `tx_valid_o` is low, `rx_ready_o` is high and all flags are clear, so the first query is answered with the no-error code.
- R2: A query (byte 0x20) accepted while no flag is pending produces exactly one output byte, 0x21.
- R3: A query accepted while an error is pending produces three bytes: the reply code, then the channel number high byte, then the low byte. The reply code is 0x22 for sequence error, 0x23 for collision and 0x24 for busy.
- R4: When several flags are pending, one query reports only one of them, in the fixed order sequence error (flag lane 0), then collision (lane 1), then busy (lane 2).
- R5: Accepting a query clears only the flag being reported. The other flags stay pending and are reported by later queries.
- R6: A flag's channel register is loaded only when an event finds the flag clear. Further events on that lane while it is pending do not change the reported channel.
- R7: If an event on a lane arrives in the same cycle that a query clears that lane's flag, the flag stays set and the new channel is captured. The current reply still carries the old channel.
- R8: Any input byte other than 0x20 is consumed with no output and no change to the flags.
- R9: While a reply frame is being sent, `rx_ready_o` is low and no query is accepted. Under output back-pressure, `tx_valid_o` and `tx_data_o` hold steady until the byte is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Input byte valid |
| rx_data_i | input | 8 | Input byte (query opcode) |
| rx_ready_o | output | 1 | Block can take an input byte |
| evt_i | input | 3 | Error event pulses: bit 0 sequence, bit 1 collision, bit 2 busy |
| evt_chan_i | input | 3x16 | Channel number for each event lane |
| tx_valid_o | output | 1 | Output byte valid |
| tx_data_o | output | 8 | Output byte |
| tx_ready_i | input | 1 | Receiver takes the output byte |

## Verification
An input byte or event driven before a rising edge takes effect at that edge. The first reply byte is therefore valid from the next falling edge, one register stage after the query is accepted. Each later byte appears one edge after the previous byte is taken. The bench drives on falling edges and samples outputs on falling edges, waiting for `tx_valid_o` instead of counting fixed delays, so back-pressure stalls of zero to several cycles do not shift its expectations. Checks that a byte was ignored are made at the falling edge right after the acceptance edge, which is the first point where a reply would be visible.

// File: rtl/err_resp_pkg.sv
package err_resp_pkg;
  localparam int NUM_ERR = 3;
  localparam int CHAN_W  = 16;
  localparam int BYTE_W  = 8;
  localparam logic [7:0] OP_QUERY    = 8'h20;
  localparam logic [7:0] OP_NO_ERR   = 8'h21;
  localparam logic [7:0] OP_ERR_BASE = 8'h22;  // + lane index
endpackage

// File: rtl/err_flag_bank.sv
module err_flag_bank #(
  parameter int NUM_ERR = 3,
  parameter int CHAN_W  = 16
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_ERR-1:0]              evt_i,
  input  logic [NUM_ERR-1:0][CHAN_W-1:0]  chan_i,
  input  logic [NUM_ERR-1:0]              clr_i,
  output logic [NUM_ERR-1:0]              flag_o,
  output logic [NUM_ERR-1:0][CHAN_W-1:0]  chan_o
);
  logic [NUM_ERR-1:0]             flag_q;
  logic [NUM_ERR-1:0][CHAN_W-1:0] chan_q;

  for (genvar g = 0; g < NUM_ERR; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_q[g] <= 1'b0;
        chan_q[g] <= '0;
      end else if (evt_i[g]) begin
        flag_q[g] <= 1'b1;
        // capture only on a fresh set (clear in same cycle counts as fresh)
        if (!flag_q[g] || clr_i[g]) chan_q[g] <= chan_i[g];
      end else if (clr_i[g]) begin
        flag_q[g] <= 1'b0;
      end
    end

    // R5
    flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[g] && !clr_i[g]) |=> flag_q[g]);
    // R6
    chan_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[g] && !clr_i[g]) |=> $stable(chan_q[g]));
    // R7
    evt_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[g] |=> flag_q[g]);
  end

  assign flag_o = flag_q;
  assign chan_o = chan_q;
endmodule

// File: rtl/err_prio_sel.sv
module err_prio_sel #(
  parameter int NUM_ERR = 3,
  localparam int IDX_W  = (NUM_ERR > 1) ? $clog2(NUM_ERR) : 1
) (
  input  logic [NUM_ERR-1:0] flag_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [NUM_ERR-1:0] sel_o
);
  // lowest lane index wins
  always_comb begin
    idx_o = '0;
    sel_o = '0;
    for (int i = NUM_ERR - 1; i >= 0; i--) begin
      if (flag_i[i]) begin
        idx_o = IDX_W'(i);
        sel_o = NUM_ERR'(1) << i;
      end
    end
  end
  assign any_o = |flag_i;
endmodule

// File: rtl/err_tx_ser.sv
module err_tx_ser #(
  parameter int BYTE_W      = 8,
  parameter int FRAME_BYTES = 3,
  localparam int CNT_W      = $clog2(FRAME_BYTES + 1),
  localparam int FRAME_W    = FRAME_BYTES * BYTE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [CNT_W-1:0]   load_len_i,
  input  logic [FRAME_W-1:0] load_data_i,  // first byte in top position
  output logic               busy_o,
  output logic               tx_valid_o,
  output logic [BYTE_W-1:0]  tx_data_o,
  input  logic               tx_ready_i
);
  logic [FRAME_W-1:0] sr_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               fire;

  assign fire       = tx_valid_o && tx_ready_i;
  assign tx_valid_o = (cnt_q != '0);
  assign busy_o     = tx_valid_o;
  assign tx_data_o  = sr_q[FRAME_W-1 -: BYTE_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (load_i && !busy_o) begin
      sr_q  <= load_data_i;
      cnt_q <= load_len_i;
    end else if (fire) begin
      sr_q  <= sr_q << BYTE_W;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R9
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));
  // R9
  load_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !busy_o);
endmodule

// File: rtl/err_status_resp.sv
module err_status_resp
  import err_resp_pkg::*;
#(
  parameter int NUM_ERR = err_resp_pkg::NUM_ERR,
  parameter int CHAN_W  = err_resp_pkg::CHAN_W,
  parameter int BYTE_W  = err_resp_pkg::BYTE_W
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            rx_valid_i,
  input  logic [BYTE_W-1:0]               rx_data_i,
  output logic                            rx_ready_o,
  input  logic [NUM_ERR-1:0]              evt_i,
  input  logic [NUM_ERR-1:0][CHAN_W-1:0]  evt_chan_i,
  output logic                            tx_valid_o,
  output logic [BYTE_W-1:0]               tx_data_o,
  input  logic                            tx_ready_i
);
  localparam int FRAME_BYTES = 1 + CHAN_W / BYTE_W;
  localparam int FRAME_W     = FRAME_BYTES * BYTE_W;
  localparam int CNT_W       = $clog2(FRAME_BYTES + 1);
  localparam int IDX_W       = (NUM_ERR > 1) ? $clog2(NUM_ERR) : 1;

  logic [NUM_ERR-1:0]             flags, sel, clr;
  logic [NUM_ERR-1:0][CHAN_W-1:0] chans;
  logic [IDX_W-1:0]               idx;
  logic                           any_err, busy, req_fire;
  logic [CHAN_W-1:0]              chan_pick;
  logic [FRAME_W-1:0]             frame;
  logic [CNT_W-1:0]               frame_len;

  assign rx_ready_o = !busy;
  assign req_fire   = rx_valid_i && rx_ready_o && (rx_data_i == BYTE_W'(OP_QUERY));
  assign clr        = req_fire ? sel : '0;

  err_flag_bank #(.NUM_ERR(NUM_ERR), .CHAN_W(CHAN_W)) u_flags (
    .clk_i, .rst_ni,
    .evt_i, .chan_i(evt_chan_i), .clr_i(clr),
    .flag_o(flags), .chan_o(chans)
  );

  err_prio_sel #(.NUM_ERR(NUM_ERR)) u_prio (
    .flag_i(flags), .any_o(any_err), .idx_o(idx), .sel_o(sel)
  );

  always_comb begin
    chan_pick = '0;
    for (int i = 0; i < NUM_ERR; i++)
      if (sel[i]) chan_pick = chans[i];
  end

  always_comb begin
    if (any_err) begin
      frame     = {BYTE_W'(OP_ERR_BASE) + BYTE_W'(idx), chan_pick};
      frame_len = CNT_W'(FRAME_BYTES);
    end else begin
      frame     = {BYTE_W'(OP_NO_ERR), {CHAN_W{1'b0}}};
      frame_len = CNT_W'(1);
    end
  end

  err_tx_ser #(.BYTE_W(BYTE_W), .FRAME_BYTES(FRAME_BYTES)) u_tx (
    .clk_i, .rst_ni,
    .load_i(req_fire), .load_len_i(frame_len), .load_data_i(frame),
    .busy_o(busy), .tx_valid_o, .tx_data_o, .tx_ready_i
  );

  // R4
  prio_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel) && ((sel & ~flags) == '0) && (any_err == (sel != '0)));
  // R5
  clr_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr) && ((clr != '0) -> req_fire));
  // R8
  ignore_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_ready_o && rx_data_i != BYTE_W'(OP_QUERY)) |=> !tx_valid_o);
  // R9
  no_req_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> !rx_ready_o);
endmodule

// File: tb/sim_err_status_resp.sv
module sim_err_status_resp;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_ready_o;
  logic [2:0] evt = '0;
  logic [2:0][15:0] evt_chan = '0;
  logic tx_valid_o;
  logic [7:0] tx_data_o;
  logic tx_ready = 1'b0;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;  // 125 MHz

  err_status_resp u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ready_o(rx_ready_o),
    .evt_i(evt), .evt_chan_i(evt_chan),
    .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .tx_ready_i(tx_ready)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    while (!rx_ready_o) @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic event_on(input int lane, input logic [15:0] ch);
    @(negedge clk);
    evt = 3'b001 << lane; evt_chan[lane] = ch;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic recv(output logic [7:0] b, input int stall);
    tx_ready = 1'b0;
    repeat (stall) @(negedge clk);
    while (!tx_valid_o) @(negedge clk);
    b = tx_data_o; tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  // query and check the full reply; op 8'h21 means no channel bytes
  task automatic query(input logic [7:0] op, input logic [15:0] ch, input int stall, input string tag);
    logic [7:0] b;
    send(8'h20);
    recv(b, stall);
    chk(b == op, {tag, " opcode"}, b, op);
    if (op != 8'h21) begin
      recv(b, stall);
      chk(b == ch[15:8], {tag, " chan hi"}, b, ch[15:8]);
      recv(b, stall);
      chk(b == ch[7:0], {tag, " chan lo"}, b, ch[7:0]);
    end
    @(negedge clk);
    chk(!tx_valid_o, {tag, " frame end"}, tx_valid_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] b;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!tx_valid_o, "R1 tx_valid in reset", tx_valid_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rx_ready_o, "R1 rx_ready after reset", rx_ready_o, 1);
    query(8'h21, 16'h0, 0, "R1 first query");
    // R2
    query(8'h21, 16'h0, 2, "R2 no error");

    // R3 R4 R5: sweep all flag patterns, drain by priority
    for (int pat = 0; pat < 8; pat++) begin
      logic [2:0] pend;
      logic [15:0] exp_ch [3];
      pend = pat[2:0];
      for (int i = 0; i < 3; i++) begin
        exp_ch[i] = 16'(pat * 256 + i * 17 + 3);
        if (pend[i]) event_on(i, exp_ch[i]);
      end
      for (int k = 0; k < 3; k++) begin
        if (pend != 0) begin
          int lo;
          lo = pend[0] ? 0 : (pend[1] ? 1 : 2);
          query(8'(8'h22 + lo), exp_ch[lo], (pat + k) % 3, "R4 R5 R3 priority drain");
          pend[lo] = 1'b0;
        end
      end
      query(8'h21, 16'h0, pat % 2, "R5 drained");
    end

    // R6 first channel kept
    event_on(1, 16'h0005);
    event_on(1, 16'h0009);
    event_on(1, 16'h00AA);
    query(8'h23, 16'h0005, 1, "R6 capture first");
    query(8'h21, 16'h0, 0, "R6 drained");

    // R7 event coincides with clear
    event_on(0, 16'h1234);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'h20;
    evt = 3'b001; evt_chan[0] = 16'h5678;
    @(negedge clk);
    rx_valid = 1'b0; evt = '0;
    recv(b, 0); chk(b == 8'h22, "R7 old opcode", b, 8'h22);
    recv(b, 0); chk(b == 8'h12, "R7 old chan hi", b, 8'h12);
    recv(b, 0); chk(b == 8'h34, "R7 old chan lo", b, 8'h34);
    query(8'h22, 16'h5678, 0, "R7 new channel kept");
    query(8'h21, 16'h0, 0, "R7 drained");

    // R8 every other opcode ignored, busy flag survives
    event_on(2, 16'hBEEF);
    for (int v = 0; v < 256; v++) begin
      if (v != 8'h20) begin
        send(8'(v));
        chk(!tx_valid_o, "R8 ignored opcode", tx_valid_o, 0);
      end
    end
    query(8'h24, 16'hBEEF, 0, "R8 flag untouched");

    // R9 no accept during reply, hold under back-pressure
    event_on(0, 16'h0102);
    event_on(1, 16'h0304);
    send(8'h20);
    chk(tx_valid_o && !rx_ready_o, "R9 busy blocks rx", rx_ready_o, 0);
    rx_valid = 1'b1; rx_data = 8'h20;
    repeat (2) @(negedge clk);
    chk(tx_valid_o && tx_data_o == 8'h22, "R9 hold under stall", tx_data_o, 8'h22);
    rx_valid = 1'b0;
    recv(b, 0); chk(b == 8'h22, "R9 opcode", b, 8'h22);
    recv(b, 1); chk(b == 8'h01, "R9 chan hi", b, 8'h01);
    recv(b, 0); chk(b == 8'h02, "R9 chan lo", b, 8'h02);
    repeat (3) @(negedge clk);
    chk(!tx_valid_o, "R9 blocked query dropped", tx_valid_o, 0);
    query(8'h23, 16'h0304, 0, "R9 collision still pending");
    query(8'h21, 16'h0, 0, "R9 drained");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule